// File: doc/BRIEF.md
# Multi-Cycle Transaction Lock Generator

This block breaks one logical bus transaction into the right number of physical bus cycles. It then drives two active-low indications: a pseudo-lock that marks an unfinished multi-cycle transaction, and a last-cycle flag that marks the final bus cycle. The transaction may be a single transfer, a 64-bit floating-point read or write, a 64-bit descriptor read, or a 128-bit cache line fill. The bus-size inputs and a cacheability input set how many cycles the transaction takes.

Each bus cycle has two phases. The first is an address clock, marked by a one-clock address strobe. After it come one or more data clocks, which end when either ready strobe is sampled. A bus-hold request freezes the sequencer and drops the output enable so that the pins can be released. While hold is active the lock and last-cycle lines read inactive.

Top module: `txn_lock_seq`

## Requirements
- R1: After reset the block is idle: `addrStrobe`=0, `lockN`=1, `lastN`=1, `outEn`=1 and `reqReady`=1.
- R2: The number of bus cycles is a base count shifted by the bus width. `reqType` encodings: 0 single, 1 FP read, 2 FP write, 3 descriptor read, 4 line fill, 5..7 single. The base is 1 for a single, 2 for types 1..3 and 4 for a cacheable line fill. `busSize` 00 (32-bit) multiplies the base by 1, 01 (16-bit) by 2, and 10 or 11 (8-bit) by 4.
- R3: Each bus cycle opens with exactly one clock of `addrStrobe`=1. It then stays in data clocks until `rdy` or `brdy` is sampled high. Ready in the address clock is ignored, and so is ready while idle.
- R4: `lastN` is 0 in every clock of the final bus cycle and 1 in every clock of any earlier cycle, except as given by R6.
- R5: `lockN` is 0 in every clock of each non-final cycle of a transaction with more than one cycle. It returns to 1 from the address clock of the final cycle, before that cycle's ready. A one-cycle transaction never drives `lockN` to 0.
- R6: In the first bus cycle of an FP write, `lockN` and `lastN` are both 0.
- R7: A line fill accepted with `cacheOk`=0 takes the single-transfer base of 1, still multiplied by the bus width (R2).
- R8: While `holdReq`=1: `outEn`=0, `addrStrobe`=0, `lockN`=`lastN`=1 and `reqReady`=0. The sequencer keeps its state, so ready is ignored. On release it resumes where it stopped.
- R9: A request is taken only on a clock with `reqValid`=1 and `reqReady`=1. `reqReady` is 1 only when the block is idle and not in hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Transaction request |
| reqType | input | 3 | Transaction kind (R2 encoding) |
| busSize | input | 2 | Bus width select (R2 encoding) |
| cacheOk | input | 1 | Cacheability, sampled with the request |
| rdy | input | 1 | Non-burst ready, active high |
| brdy | input | 1 | Burst ready, active high |
| holdReq | input | 1 | Bus hold request |
| reqReady | output | 1 | Block can take a request |
| addrStrobe | output | 1 | Address clock of a bus cycle |
| lockN | output | 1 | Pseudo-lock, active low |
| lastN | output | 1 | Last-cycle indication, active low |
| outEn | output | 1 | Output enable for the bus indications |

## Verification
A wrong beat count shows at the ports within one bus cycle of the fault. `lastN` falls a cycle early or late, `lockN` stays low into the final cycle, and the count of address strobes before `reqReady` returns is off. A lost first-cycle flag shows in the first address clock of an FP write, where `lastN` stays high. A sequencer that moves during hold shows in the first clock after release, as an address strobe or an early return to idle where the bench expects a data clock.

// File: rtl/txn_seq_pkg.sv
package txn_seq_pkg;

  typedef enum logic [2:0] {
    TX_SINGLE    = 3'd0,
    TX_FP_RD     = 3'd1,
    TX_FP_WR     = 3'd2,
    TX_DESC_RD   = 3'd3,
    TX_LINE_FILL = 3'd4
  } txnKind_e;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ADDR = 2'd1,
    SEQ_DATA = 2'd2
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;       // request accepted this clock
    logic step;       // a non-final cycle finished this clock
    logic addrPhase;  // address clock of a bus cycle
    logic active;     // a transaction is in flight
    logic frozen;     // bus hold in effect
  } seqCtl_s;

endpackage

// File: rtl/txn_seq_ctrl.sv
module txn_seq_ctrl
  import txn_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    reqValid,
  input  logic    holdReq,
  input  logic    rdy,
  input  logic    brdy,
  input  logic    lastBeat,
  output seqCtl_s ctl,
  output logic    reqReady
);

  seqState_e state, stateNext;
  logic readyTaken;

  assign reqReady   = (state == SEQ_IDLE) && !holdReq;
  assign readyTaken = (state == SEQ_DATA) && !holdReq && (rdy || brdy);

  always_comb begin
    ctl.load      = reqReady && reqValid;
    ctl.step      = readyTaken && !lastBeat;
    ctl.addrPhase = (state == SEQ_ADDR) && !holdReq;
    ctl.active    = (state != SEQ_IDLE);
    ctl.frozen    = holdReq;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      SEQ_IDLE: if (ctl.load) stateNext = SEQ_ADDR;
      SEQ_ADDR: if (!holdReq) stateNext = SEQ_DATA;
      SEQ_DATA: if (readyTaken) stateNext = lastBeat ? SEQ_IDLE : SEQ_ADDR;
      default:  stateNext = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= SEQ_IDLE;
    else     state <= stateNext;
  end

  // R3
  addr_one_clock_chk: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_ADDR && !holdReq) |=> (state == SEQ_DATA));

  // R8
  hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    holdReq |=> (state == $past(state)));

  // R9
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (state != SEQ_IDLE) |-> !reqReady);

endmodule

// File: rtl/txn_seq_path.sv
module txn_seq_path
  import txn_seq_pkg::*;
#(
  parameter int WIDE_BEATS = 2,
  parameter int FILL_BEATS = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  seqCtl_s    ctl,
  input  logic [2:0] reqType,
  input  logic [1:0] busSize,
  input  logic       cacheOk,
  output logic       lastBeat,
  output logic       addrStrobe,
  output logic       lockN,
  output logic       lastN,
  output logic       outEn
);

  localparam int MAX_BEATS = FILL_BEATS * 4;
  localparam int CNT_W     = $clog2(MAX_BEATS + 1);

  logic [CNT_W-1:0] remaining, baseBeats, totalBeats;
  logic [1:0]       widthShift;
  logic             multiCyc, fpWrite, firstCyc, driveOk;

  always_comb begin
    unique case (txnKind_e'(reqType))
      TX_FP_RD, TX_FP_WR, TX_DESC_RD: baseBeats = CNT_W'(WIDE_BEATS);
      TX_LINE_FILL: baseBeats = cacheOk ? CNT_W'(FILL_BEATS) : CNT_W'(1);
      default:      baseBeats = CNT_W'(1);
    endcase
    unique case (busSize)
      2'b00:   widthShift = 2'd0;
      2'b01:   widthShift = 2'd1;
      default: widthShift = 2'd2;
    endcase
    totalBeats = baseBeats << widthShift;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      remaining <= '0;
      multiCyc  <= 1'b0;
      fpWrite   <= 1'b0;
      firstCyc  <= 1'b0;
    end else if (ctl.load) begin
      remaining <= totalBeats;
      multiCyc  <= (totalBeats > CNT_W'(1));
      fpWrite   <= (reqType == TX_FP_WR);
      firstCyc  <= 1'b1;
    end else if (ctl.step) begin
      remaining <= remaining - CNT_W'(1);
      firstCyc  <= 1'b0;
    end
  end

  assign lastBeat   = (remaining == CNT_W'(1));
  assign driveOk    = ctl.active && !ctl.frozen;
  assign addrStrobe = ctl.addrPhase;
  assign outEn      = !ctl.frozen;
  assign lastN      = !(driveOk && (lastBeat || (fpWrite && firstCyc)));
  assign lockN      = !(driveOk && multiCyc && !lastBeat);

  // R2
  load_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.load |=> (remaining != '0));

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.step |=> (remaining == $past(remaining) - CNT_W'(1)));

  // R5
  lock_last_inverse_chk: assert property (@(posedge clk) disable iff (rst)
    (driveOk && !(fpWrite && firstCyc)) |-> (lockN != lastN));

  // R8
  hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.frozen |-> (!outEn && lockN && lastN && !addrStrobe));

  // R4
  idle_lines_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl.active |-> (lockN && lastN));

endmodule

// File: rtl/txn_lock_seq.sv
module txn_lock_seq
  import txn_seq_pkg::*;
#(
  parameter int WIDE_BEATS = 2,
  parameter int FILL_BEATS = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reqValid,
  input  logic [2:0] reqType,
  input  logic [1:0] busSize,
  input  logic       cacheOk,
  input  logic       rdy,
  input  logic       brdy,
  input  logic       holdReq,
  output logic       reqReady,
  output logic       addrStrobe,
  output logic       lockN,
  output logic       lastN,
  output logic       outEn
);

  seqCtl_s ctl;
  logic    lastBeat;

  txn_seq_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .holdReq  (holdReq),
    .rdy      (rdy),
    .brdy     (brdy),
    .lastBeat (lastBeat),
    .ctl      (ctl),
    .reqReady (reqReady)
  );

  txn_seq_path #(
    .WIDE_BEATS (WIDE_BEATS),
    .FILL_BEATS (FILL_BEATS)
  ) u_path (
    .clk        (clk),
    .rst        (rst),
    .ctl        (ctl),
    .reqType    (reqType),
    .busSize    (busSize),
    .cacheOk    (cacheOk),
    .lastBeat   (lastBeat),
    .addrStrobe (addrStrobe),
    .lockN      (lockN),
    .lastN      (lastN),
    .outEn      (outEn)
  );

endmodule

// File: tb/tb_txn_lock_seq.sv
module tb_txn_lock_seq;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 1'b0;
  logic [2:0] reqType = 3'd0;
  logic [1:0] busSize = 2'd0;
  logic cacheOk = 1'b0;
  logic rdy = 1'b0;
  logic brdy = 1'b0;
  logic holdReq = 1'b0;
  logic reqReady, addrStrobe, lockN, lastN, outEn;

  int testsRun = 0;
  int testsFailed = 0;

  always #2 clk = ~clk;  // 250 MHz

  txn_lock_seq dut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqType(reqType),
    .busSize(busSize), .cacheOk(cacheOk), .rdy(rdy), .brdy(brdy),
    .holdReq(holdReq), .reqReady(reqReady), .addrStrobe(addrStrobe),
    .lockN(lockN), .lastN(lastN), .outEn(outEn)
  );

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // packed view: {reqReady, addrStrobe, lockN, lastN, outEn}
  function automatic logic [4:0] outs();
    return {reqReady, addrStrobe, lockN, lastN, outEn};
  endfunction

  function automatic int beatsFor(input int kind, input int size, input bit ken);
    int base;
    base = (kind >= 1 && kind <= 3) ? 2 : (kind == 4 ? (ken ? 4 : 1) : 1);
    return base * (size == 0 ? 1 : (size == 1 ? 2 : 4));
  endfunction

  // one full transaction; earlyRdy drives ready in each address clock (R3)
  task automatic runTxn(input string name, input int kind, input int size, input bit ken,
                        input int waits, input bit earlyRdy);
    int n;
    bit lk, ls;
    n = beatsFor(kind, size, ken);
    @(negedge clk);
    check({name, " R9 ready before request"}, {4'b0, reqReady}, 5'b1);
    reqValid = 1'b1; reqType = kind[2:0]; busSize = size[1:0]; cacheOk = ken;
    @(negedge clk);
    reqValid = 1'b0; cacheOk = ~ken;
    for (int i = 0; i < n; i++) begin
      lk = (n > 1) && (i != n - 1);                    // R5
      ls = (i == n - 1) || (kind == 2 && i == 0);      // R4 R6
      check($sformatf("%s R2 R3 R4 R5 R6 addr clock cycle %0d", name, i),
            outs(), {1'b0, 1'b1, ~lk, ~ls, 1'b1});
      rdy = earlyRdy;
      @(negedge clk);
      rdy = 1'b0;
      check($sformatf("%s R3 R4 R5 data clock cycle %0d", name, i),
            outs(), {1'b0, 1'b0, ~lk, ~ls, 1'b1});
      for (int w = 0; w < waits; w++) begin
        @(negedge clk);
        check($sformatf("%s R3 wait clock cycle %0d", name, i),
              outs(), {1'b0, 1'b0, ~lk, ~ls, 1'b1});
      end
      if (i % 2 == 0) rdy = 1'b1; else brdy = 1'b1;
      @(negedge clk);
      rdy = 1'b0; brdy = 1'b0;
    end
    check({name, " R2 idle after final cycle"}, outs(), 5'b10111);
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1 reset state", outs(), 5'b10111);
    rst = 1'b0;
  endtask

  task automatic testIdleReady();
    @(negedge clk);
    rdy = 1'b1; brdy = 1'b1;
    @(negedge clk);
    rdy = 1'b0; brdy = 1'b0;
    check("R3 ready while idle ignored", outs(), 5'b10111);
  endtask

  task automatic testHold();
    int strobes;
    // hold while idle blocks acceptance
    @(negedge clk);
    holdReq = 1'b1; reqValid = 1'b1; reqType = 3'd4; busSize = 2'd0; cacheOk = 1'b1;
    #1;
    check("R8 R9 hold while idle", outs(), 5'b00110);
    @(negedge clk);
    holdReq = 1'b0; reqValid = 1'b0;
    @(negedge clk);
    check("R9 request during hold not taken", outs(), 5'b10111);
    // hold inside a line fill data clock, with ready pending
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    check("R5 fill first addr clock", outs(), 5'b01011);
    @(negedge clk);
    holdReq = 1'b1; rdy = 1'b1;
    for (int k = 0; k < 3; k++) begin
      #1;
      check("R8 outputs released in hold", outs(), 5'b00110);
      @(negedge clk);
    end
    holdReq = 1'b0; rdy = 1'b0;
    #1;
    check("R8 resumes in same data clock", outs(), 5'b00011);
    rdy = 1'b1;
    strobes = 0;
    for (int k = 0; k < 20 && !reqReady; k++) begin
      @(negedge clk);
      if (addrStrobe) strobes++;
    end
    rdy = 1'b0;
    check("R8 remaining cycles after hold", 5'(strobes), 5'd3);
  endtask

  initial begin
    #200000;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    testReset();
    testIdleReady();
    runTxn("single32", 0, 0, 1'b0, 0, 1'b1);
    runTxn("fprd32",   1, 0, 1'b0, 2, 1'b1);
    runTxn("fpwr32",   2, 0, 1'b0, 1, 1'b0);
    runTxn("desc16",   3, 1, 1'b0, 0, 1'b1);
    runTxn("fill32",   4, 0, 1'b1, 0, 1'b0);
    runTxn("R7 fill32 nocache", 4, 0, 1'b0, 1, 1'b1);
    runTxn("R7 fill16 nocache", 4, 1, 1'b0, 0, 1'b0);
    runTxn("fill8",    4, 2, 1'b1, 0, 1'b1);
    runTxn("fpwr8",    2, 3, 1'b0, 0, 1'b0);
    runTxn("single8",  0, 3, 1'b0, 1, 1'b0);
    runTxn("kind7_32", 7, 0, 1'b1, 0, 1'b0);
    testHold();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule